// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the effective address of a data operand for a 64-bit load/store pipeline. It receives the operands that the register file has already read, a 16-bit displacement and a few control bits, and it adds them in one of two ways. In displacement form, the sign-extended displacement is added to the base. In indexed form, the index value is added to the base. A flag can replace the base with a literal zero. A second flag can replace the index with zero, which string-immediate operations use.

In 32-bit mode the upper half of the sum is cleared, so the arithmetic wraps modulo 2^32. In 64-bit mode it wraps modulo 2^64. Alongside the address the block reports two things for the requested access size. The first is whether the address is naturally aligned. The second is whether the operand's last byte falls past the top of the address space for the current mode, so that the access continues from address zero.

A parameter chooses between a purely combinational path and a single output register. The register loads when the valid input is high and clears on synchronous reset.

Top module: `lsu_ea_gen`

## Requirements
- R1: With mode_indexed low, ea equals the base operand plus the 16-bit displacement sign-extended to 64 bits, modulo 2^64.
- R2: When base_is_zero is high, the base operand is the constant zero instead of base_val, in both addressing forms.
- R3: With mode_indexed high, ea equals the base operand plus index_val. When string_imm is also high, the index operand is zero. string_imm has no effect when mode_indexed is low.
- R4: When mode32 is high, ea[63:32] is zero and ea[31:0] is the 32-bit sum modulo 2^32.
- R5: acc_size encodes 00 byte, 01 halfword, 10 word, 11 doubleword. aligned is high as follows: always for a byte; for a halfword when ea[0]=0; for a word when ea[1:0]=00; for a doubleword when ea[2:0]=000.
- R6: wraps is high exactly when ea plus the access length minus one exceeds 2^64-1 in 64-bit mode, or 2^32-1 (computed on ea[31:0]) in 32-bit mode. A byte access never wraps.
- R7: With the output register enabled (the default), ea, aligned and wraps take the values for the inputs sampled at a rising edge where in_valid is high. They hold their previous values when in_valid is low.
- R8: A synchronous active-high rst clears ea, aligned and wraps to zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load enable for the output register |
| base_val | input | 64 | Base register contents |
| index_val | input | 64 | Index register contents |
| base_is_zero | input | 1 | Use a literal zero in place of the base |
| disp | input | 16 | Signed displacement |
| mode_indexed | input | 1 | 0: base + displacement, 1: base + index |
| string_imm | input | 1 | Zero the index operand (indexed form only) |
| mode32 | input | 1 | 1: 32-bit address mode |
| acc_size | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 double |
| ea | output | 64 | Effective address |
| aligned | output | 1 | Natural alignment for acc_size |
| wraps | output | 1 | Operand crosses the top of the address space |

## Verification
Random operands almost never produce a boundary crossing. To report one, the address must land within seven bytes of the top of a 2^64 or 2^32 space. Directed tasks therefore build those addresses on purpose. They take an all-ones base with small displacements, the most negative displacement against a zero base, and 32-bit sums whose upper half overflows and is discarded. Each address is then swept over every access size, so that the exact last address that does not wrap and the first address that does are both seen. Every output is compared against a model in the bench, one cycle after the registered capture.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } acc_size_e;

    typedef enum logic {
        FORM_DISP  = 1'b0,
        FORM_INDEX = 1'b1
    } addr_form_e;

    // Offset of the last byte of an operand: length minus one.
    function automatic logic [2:0] last_byte_off(input acc_size_e sz);
        case (sz)
            SZ_BYTE:  return 3'd0;
            SZ_HALF:  return 3'd1;
            SZ_WORD:  return 3'd3;
            default:  return 3'd7;
        endcase
    endfunction

    // Natural alignment from the three low address bits.
    function automatic logic is_natural(input acc_size_e sz, input logic [2:0] low);
        case (sz)
            SZ_BYTE:  return 1'b1;
            SZ_HALF:  return low[0] == 1'b0;
            SZ_WORD:  return low[1:0] == 2'b00;
            default:  return low == 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/agu_operand_sel.sv
module agu_operand_sel
    import agu_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic              base_is_zero,
    input  logic [DISP_W-1:0] disp,
    input  addr_form_e        form,
    input  logic              string_imm,
    output logic [ADDR_W-1:0] opa,
    output logic [ADDR_W-1:0] opb
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

    always_comb begin
        opa = base_is_zero ? '0 : base_val;
        if (form == FORM_INDEX)
            opb = string_imm ? '0 : index_val;
        else
            opb = disp_ext;
    end
endmodule

// File: rtl/agu_sum_mask.sv
module agu_sum_mask #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] opa,
    input  logic [ADDR_W-1:0] opb,
    input  logic              mode32,
    output logic [ADDR_W-1:0] ea
);
    localparam int HALF_W = ADDR_W / 2;

    logic [ADDR_W-1:0] raw;

    assign raw = opa + opb;

    always_comb begin
        ea = raw;
        if (mode32)
            ea[ADDR_W-1:HALF_W] = '0;
    end
endmodule

// File: rtl/agu_attr.sv
module agu_attr
    import agu_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] ea,
    input  logic              mode32,
    input  acc_size_e         acc_size,
    output logic              aligned,
    output logic              wraps
);
    localparam int HALF_W = ADDR_W / 2;
    localparam int PAD_W  = ADDR_W + 1 - 3;

    logic [ADDR_W:0] start_ext;
    logic [ADDR_W:0] last_ext;

    always_comb begin
        start_ext = {1'b0, ea};
        if (mode32)
            start_ext[ADDR_W:HALF_W] = '0;
        last_ext = start_ext + {{PAD_W{1'b0}}, last_byte_off(acc_size)};
        if (mode32)
            wraps = last_ext[ADDR_W:HALF_W] != '0;
        else
            wraps = last_ext[ADDR_W];
        aligned = is_natural(acc_size, ea[2:0]);
    end
endmodule

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
    import agu_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int DISP_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic              base_is_zero,
    input  logic [DISP_W-1:0] disp,
    input  logic              mode_indexed,
    input  logic              string_imm,
    input  logic              mode32,
    input  logic [1:0]        acc_size,
    output logic [ADDR_W-1:0] ea,
    output logic              aligned,
    output logic              wraps
);
    localparam int HALF_W = ADDR_W / 2;

    logic [ADDR_W-1:0] opa, opb, ea_c;
    logic              aligned_c, wraps_c;
    acc_size_e         size_e;
    addr_form_e        form_e;

    assign size_e = acc_size_e'(acc_size);
    assign form_e = addr_form_e'(mode_indexed);

    agu_operand_sel #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_sel (
        .base_val    (base_val),
        .index_val   (index_val),
        .base_is_zero(base_is_zero),
        .disp        (disp),
        .form        (form_e),
        .string_imm  (string_imm),
        .opa         (opa),
        .opb         (opb)
    );

    agu_sum_mask #(.ADDR_W(ADDR_W)) u_sum (
        .opa   (opa),
        .opb   (opb),
        .mode32(mode32),
        .ea    (ea_c)
    );

    agu_attr #(.ADDR_W(ADDR_W)) u_attr (
        .ea      (ea_c),
        .mode32  (mode32),
        .acc_size(size_e),
        .aligned (aligned_c),
        .wraps   (wraps_c)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    ea      <= '0;
                    aligned <= 1'b0;
                    wraps   <= 1'b0;
                end else if (in_valid) begin
                    ea      <= ea_c;
                    aligned <= aligned_c;
                    wraps   <= wraps_c;
                end
            end

            // R4
            upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && mode32) |=> (ea[ADDR_W-1:HALF_W] == '0));

            // R1
            zero_base_disp_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && base_is_zero && !mode_indexed && !mode32)
                |=> (ea == {{(ADDR_W-DISP_W){$past(disp[DISP_W-1])}}, $past(disp)}));

            // R6
            byte_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && acc_size == 2'b00) |=> (!wraps && aligned));

            // R7
            hold_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> ($stable(ea) && $stable(aligned) && $stable(wraps)));

            // R3
            string_zero_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && mode_indexed && string_imm && base_is_zero) |=> (ea == '0));

            // R8
            reset_clear_chk: assert property (@(posedge clk)
                rst |=> (ea == '0 && !aligned && !wraps));
        end else begin : g_comb
            assign ea      = ea_c;
            assign aligned = aligned_c;
            assign wraps   = wraps_c;
        end
    endgenerate
endmodule

// File: tb/sim_lsu_ea_gen.sv
`timescale 1ns/1ps
module sim_lsu_ea_gen;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] base_val, index_val;
    logic        base_is_zero;
    logic [15:0] disp;
    logic        mode_indexed, string_imm, mode32;
    logic [1:0]  acc_size;
    logic [63:0] ea;
    logic        aligned, wraps;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_ea_gen u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .base_val(base_val), .index_val(index_val),
        .base_is_zero(base_is_zero), .disp(disp),
        .mode_indexed(mode_indexed), .string_imm(string_imm),
        .mode32(mode32), .acc_size(acc_size),
        .ea(ea), .aligned(aligned), .wraps(wraps)
    );

    // Reference model built from the requirements.
    task automatic model(output logic [63:0] m_ea, output logic m_al, output logic m_wr);
        logic [63:0] a, b, s;
        logic [64:0] last;
        logic [2:0]  off;
        a = base_is_zero ? 64'd0 : base_val;                       // R2
        if (mode_indexed) b = string_imm ? 64'd0 : index_val;      // R3
        else              b = {{48{disp[15]}}, disp};              // R1
        s = a + b;
        if (mode32) s[63:32] = 32'd0;                              // R4
        off = (acc_size == 2'd0) ? 3'd0 : (acc_size == 2'd1) ? 3'd1 :
              (acc_size == 2'd2) ? 3'd3 : 3'd7;
        case (acc_size)                                            // R5
            2'd0: m_al = 1'b1;
            2'd1: m_al = s[0] == 1'b0;
            2'd2: m_al = s[1:0] == 2'b00;
            default: m_al = s[2:0] == 3'b000;
        endcase
        last = {1'b0, s} + {62'd0, off};                           // R6
        m_wr = mode32 ? (last[64:32] != 33'd0) : last[64];
        m_ea = s;
    endtask

    task automatic check(input string req, input logic [63:0] e_ea, input logic e_al, input logic e_wr);
        n_checks++;
        if (ea !== e_ea || aligned !== e_al || wraps !== e_wr) begin
            n_fail++;
            $display("FAIL %s: got ea=%h al=%b wr=%b expected ea=%h al=%b wr=%b",
                     req, ea, aligned, wraps, e_ea, e_al, e_wr);
        end
    endtask

    task automatic apply(input logic [63:0] b, input logic [63:0] x, input logic bz,
                         input logic [15:0] d, input logic idx, input logic si,
                         input logic m32, input logic [1:0] sz, input string req);
        logic [63:0] m_ea;
        logic m_al, m_wr;
        @(negedge clk);
        base_val = b; index_val = x; base_is_zero = bz; disp = d;
        mode_indexed = idx; string_imm = si; mode32 = m32; acc_size = sz;
        in_valid = 1'b1;
        model(m_ea, m_al, m_wr);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, m_ea, m_al, m_wr);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        base_val = 64'hFFFF_FFFF_FFFF_FFF9; base_is_zero = 1'b0; disp = 16'h0;
        mode_indexed = 1'b0; string_imm = 1'b0; mode32 = 1'b0; acc_size = 2'd3;
        index_val = 64'd0;
        @(negedge clk);
        check("R8 reset", 64'd0, 1'b0, 1'b0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    task automatic t_disp();
        apply(64'h0000_1000_0000_0000, 64'h5, 1'b0, 16'h0010, 1'b0, 1'b0, 1'b0, 2'd3, "R1 positive disp");
        apply(64'h0000_0000_0000_0100, 64'h5, 1'b0, 16'hFFF0, 1'b0, 1'b0, 1'b0, 2'd2, "R1 negative disp");
        apply(64'h1234, 64'h5, 1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, 2'd0, "R1 R2 most negative disp, zero base");
        check("R1 value", 64'hFFFF_FFFF_FFFF_8000, 1'b1, 1'b0);
        apply(64'h1234, 64'h99, 1'b0, 16'h0004, 1'b0, 1'b1, 1'b0, 2'd1, "R3 string_imm ignored in disp form");
        check("R3 value", 64'h1238, 1'b1, 1'b0);
    endtask

    task automatic t_index();
        apply(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0040, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 2'd3, "R3 indexed");
        apply(64'hAAAA, 64'h0000_0000_0000_0020, 1'b1, 16'h0, 1'b1, 1'b0, 1'b0, 2'd2, "R2 zero base indexed");
        check("R2 value", 64'h20, 1'b1, 1'b0);
        apply(64'h0000_0000_0000_0101, 64'h7777, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 2'd1, "R3 string_imm zeroes index");
        check("R3 value", 64'h101, 1'b0, 1'b0);
    endtask

    task automatic t_mode32();
        apply(64'h1234_5678_FFFF_FFFF, 64'h0, 1'b0, 16'h0001, 1'b0, 1'b0, 1'b1, 2'd0, "R4 32-bit wrap");
        check("R4 value", 64'd0, 1'b1, 1'b0);
        apply(64'hDEAD_BEEF_0000_1000, 64'h0, 1'b0, 16'h0008, 1'b0, 1'b0, 1'b1, 2'd3, "R4 upper cleared");
        check("R4 value", 64'h1008, 1'b1, 1'b0);
    endtask

    task automatic t_boundary();
        for (int sz = 0; sz < 4; sz++) begin
            for (int k = 0; k < 8; k++) begin
                apply(64'hFFFF_FFFF_FFFF_FFF8 + 64'(k), 64'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 2'(sz), "R5 R6 top of 64-bit space");
                apply(64'h0000_0000_FFFF_FFF8 + 64'(k), 64'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 2'(sz), "R5 R6 top of 32-bit space");
            end
        end
        apply(64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 2'd3, "R6 last dword fits");
        check("R6 value", 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 1'b0);
        apply(64'hFFFF_FFFF_FFFF_FFF9, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 2'd3, "R6 dword crosses");
        check("R6 value", 64'hFFFF_FFFF_FFFF_FFF9, 1'b0, 1'b1);
        apply(64'h0000_0000_FFFF_FFFD, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 2'd2, "R6 word crosses 32-bit top");
        check("R6 value", 64'h0000_0000_FFFF_FFFD, 1'b0, 1'b1);
    endtask

    task automatic t_hold();
        logic [63:0] e0;
        logic a0, w0;
        apply(64'h0000_0000_0000_0042, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 2'd1, "R7 capture");
        e0 = ea; a0 = aligned; w0 = wraps;
        @(negedge clk);
        base_val = 64'hFFFF_FFFF_FFFF_FFFF; acc_size = 2'd3; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R7 hold without valid", e0, a0, w0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 16'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                  "R1 R2 R3 R4 R5 R6 random");
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0;
        base_val = '0; index_val = '0; base_is_zero = 1'b0; disp = '0;
        mode_indexed = 1'b0; string_imm = 1'b0; mode32 = 1'b0; acc_size = 2'd0;
        repeat (2) @(negedge clk);
        t_reset();
        t_disp();
        t_index();
        t_mode32();
        t_boundary();
        t_hold();
        t_random();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule